// File: doc/BRIEF.md
# Link Power Status Monitor

This block sits between a link-layer controller and the PHY side of a PHY-to-link interface. It watches a status line that the controller drives while it is powered. It decides whether the interface runs normally, sits in a low-power reset, or is fully disabled. The status line may be a steady high, or a pulse train that crosses an isolation barrier. For that reason the block measures how long the line stays low in system-clock cycles, rather than reacting to any single low sample.

Two cycle thresholds set the behaviour. A low run a little longer than the first threshold puts the interface into reset: the control, data and request paths are forced to zero, and the system clock keeps running. A low run longer than the second threshold also stops the system clock. The first high sample after synchronisation returns the interface to normal operation. A software control bit is combined with the status to give a single link-active indication. Both a hardware reset and a power-down input leave the interface disabled.

Top module: `link_power_monitor`

## Requirements
- R1: The status input passes through two synchronising flops. The first high sample returns the state to active (code 2'b00) on the third rising edge after the input rises, and releases the output gating in that same cycle.
- R2: When the synchronised status is sampled low on more than RESET_LIMIT (128) consecutive cycles, the state becomes low-power reset (code 2'b01). A low run of RESET_LIMIT samples or fewer leaves the state active.
- R3: While the state is reset or disabled, ctl_out, data_out and req_out are held at zero, whatever the values on ctl_in, data_in and req_in.
- R4: sysclk_en is 1 in the active state and in the reset state.
- R5: When the low run exceeds DISABLE_LIMIT (1280) samples, the state becomes disabled (code 2'b10) and sysclk_en is 0.
- R6: The low-time count saturates. An arbitrarily long low run keeps the state disabled and never returns it to active or reset.
- R7: While rst_n is low, and after it is released with the status low, the state is disabled.
- R8: pwr_down high forces the disabled state at the next rising edge and clears the synchroniser. After pwr_down falls with the status high, the state returns to active on the third edge.
- R9: link_active is 1 only when the state is active and link_ctrl is 1. Otherwise it is 0.
- R10: A pulsed status whose low periods are each at most RESET_LIMIT samples keeps the state active throughout.
- R11: In the active state, ctl_out, data_out and req_out equal ctl_in, data_in and req_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pwr_down | input | 1 | Synchronous power-down; forces disabled state |
| status_in | input | 1 | Raw link power status from the link controller |
| link_ctrl | input | 1 | Software link-enable control bit |
| ctl_in | input | CTL_W | Interface control value from the PHY core |
| data_in | input | DATA_W | Interface data value from the PHY core |
| req_in | input | 1 | Request line from the link controller |
| ctl_out | output | CTL_W | Gated control toward the link |
| data_out | output | DATA_W | Gated data toward the link |
| req_out | output | 1 | Gated request toward the PHY core |
| sysclk_en | output | 1 | System clock output enable |
| pwr_state | output | 2 | 00 active, 01 reset, 10 disabled |
| link_active | output | 1 | Status active and control bit set |

## Verification
The bench builds the block with its default limits of 128 and 1280 cycles, and with 8-bit data and 2-bit control. The thresholds sit exactly where the requirements put them, so the last low sample that still counts as active and the first that counts as inactive can both be hit on exact edges. The full disable window plus several hundred saturated cycles still fits well inside the run budget. Pulsed-status runs, 128- and 129-sample glitches, and a power-down in the middle of activity exercise the synchroniser latency and the release edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'b00,
        PS_RESET    = 2'b01,
        PS_DISABLED = 2'b10
    } pwr_state_e;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = chain_q;
        if (clear) begin
            chain_d = '0;
        end else begin
            chain_d[0] = async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_d[i] = chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
    parameter int SAT_VALUE = 1281,
    localparam int CNT_W = $clog2(SAT_VALUE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_sat,
    input  logic             level,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VALUE);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (force_sat)        cnt_d = SAT;
        else if (level)       cnt_d = '0;
        else if (cnt_q < SAT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= SAT;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next = cnt_d;

endmodule

// File: rtl/lpm_state_fsm.sv
module lpm_state_fsm
    import lpm_pkg::*;
#(
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280,
    parameter int CNT_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             level,
    input  logic [CNT_W-1:0] low_cnt,
    output pwr_state_e       state
);

    typedef struct packed {
        pwr_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d;
    fsm_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (pwr_down) begin
            r_d.st = PS_DISABLED;
        end else if (level) begin
            r_d.st = PS_ACTIVE;
        end else if (int'(low_cnt) > DISABLE_LIMIT) begin
            r_d.st = PS_DISABLED;
        end else if (int'(low_cnt) > RESET_LIMIT) begin
            if (r_q.st != PS_DISABLED) r_d.st = PS_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_DISABLED};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
    import lpm_pkg::*;
#(
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280,
    parameter int DATA_W        = 8,
    parameter int CTL_W         = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              status_in,
    input  logic              link_ctrl,
    input  logic [CTL_W-1:0]  ctl_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              req_in,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [DATA_W-1:0] data_out,
    output logic              req_out,
    output logic              sysclk_en,
    output logic [1:0]        pwr_state,
    output logic              link_active
);

    localparam int SAT_VALUE = DISABLE_LIMIT + 1;
    localparam int CNT_W     = $clog2(SAT_VALUE + 1);

    logic             level_sync;
    logic [CNT_W-1:0] low_cnt;
    pwr_state_e       state;
    logic             pass;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pwr_down),
        .async_in (status_in),
        .sync_out (level_sync)
    );

    lpm_low_timer #(.SAT_VALUE(SAT_VALUE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_sat (pwr_down),
        .level     (level_sync),
        .cnt_next  (low_cnt)
    );

    lpm_state_fsm #(
        .RESET_LIMIT   (RESET_LIMIT),
        .DISABLE_LIMIT (DISABLE_LIMIT),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .level    (level_sync),
        .low_cnt  (low_cnt),
        .state    (state)
    );

    always_comb begin
        pass        = (state == PS_ACTIVE);
        ctl_out     = pass ? ctl_in  : '0;
        data_out    = pass ? data_in : '0;
        req_out     = pass & req_in;
        sysclk_en   = (state != PS_DISABLED);
        pwr_state   = state;
        link_active = pass & link_ctrl;
    end

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              link_ctrl,
    input logic [CTL_W-1:0]  ctl_out,
    input logic [DATA_W-1:0] data_out,
    input logic              req_out,
    input logic              sysclk_en,
    input logic [1:0]        pwr_state,
    input logic              link_active
);

    AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'b00) |-> (ctl_out == '0 && data_out == '0 && !req_out)); // R3

    AST_CLK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'b10) |-> sysclk_en); // R4

    AST_CLK_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b10) |-> !sysclk_en); // R5

    AST_NO_SKIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'b00 && !$past(pwr_down)) |-> (pwr_state != 2'b10)); // R2

    AST_PWR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (pwr_state == 2'b10)); // R8

    AST_LINK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        link_active |-> (link_ctrl && pwr_state == 2'b00)); // R9

    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11); // R1

endmodule

bind link_power_monitor lpm_checker #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_lpm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down    (pwr_down),
    .link_ctrl   (link_ctrl),
    .ctl_out     (ctl_out),
    .data_out    (data_out),
    .req_out     (req_out),
    .sysclk_en   (sysclk_en),
    .pwr_state   (pwr_state),
    .link_active (link_active)
);

// File: tb/link_power_monitor_test.sv
`timescale 1ns/1ps
module link_power_monitor_test;

    localparam logic [1:0] ST_ACT = 2'b00;
    localparam logic [1:0] ST_RST = 2'b01;
    localparam logic [1:0] ST_DIS = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       status_in = 1'b0;
    logic       link_ctrl = 1'b1;
    logic [1:0] ctl_in = 2'b11;
    logic [7:0] data_in = 8'hA5;
    logic       req_in = 1'b1;
    logic [1:0] ctl_out;
    logic [7:0] data_out;
    logic       req_out;
    logic       sysclk_en;
    logic [1:0] pwr_state;
    logic       link_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    link_power_monitor uut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .status_in(status_in),
        .link_ctrl(link_ctrl), .ctl_in(ctl_in), .data_in(data_in), .req_in(req_in),
        .ctl_out(ctl_out), .data_out(data_out), .req_out(req_out),
        .sysclk_en(sysclk_en), .pwr_state(pwr_state), .link_active(link_active)
    );

    typedef struct packed {
        logic       lvl;
        logic [15:0] hold;
        logic       lctrl;
        logic [1:0] exp_st;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd2,    1'b1, ST_DIS},   // R1 still syncing
        '{1'b1, 16'd1,    1'b1, ST_ACT},   // R1 third edge
        '{1'b1, 16'd10,   1'b0, ST_ACT},   // R9 ctrl low
        '{1'b0, 16'd130,  1'b1, ST_ACT},   // R2 128 low samples
        '{1'b0, 16'd1,    1'b1, ST_RST},   // R2 129th sample
        '{1'b0, 16'd1151, 1'b1, ST_RST},   // R4 reset keeps clock
        '{1'b0, 16'd1,    1'b1, ST_DIS},   // R5
        '{1'b0, 16'd900,  1'b1, ST_DIS},   // R6 saturation
        '{1'b1, 16'd2,    1'b1, ST_DIS},   // R1
        '{1'b1, 16'd1,    1'b1, ST_ACT},   // R1
        '{1'b0, 16'd128,  1'b1, ST_ACT},   // glitch of 128
        '{1'b1, 16'd2,    1'b1, ST_ACT},
        '{1'b1, 16'd1,    1'b1, ST_ACT},   // R2 never left active
        '{1'b0, 16'd129,  1'b1, ST_ACT},   // glitch of 129
        '{1'b1, 16'd1,    1'b1, ST_ACT},
        '{1'b1, 16'd1,    1'b1, ST_RST},   // R2 brief reset
        '{1'b1, 16'd1,    1'b1, ST_ACT},   // R1 release
        '{1'b1, 16'd5,    1'b1, ST_ACT}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input logic [1:0] exp_st, input logic lctrl);
        bit pass_exp;
        pass_exp = (exp_st == ST_ACT);
        check(pwr_state == exp_st, "R2 state", pwr_state, exp_st);
        check(sysclk_en == (exp_st != ST_DIS), "R4 sysclk_en", sysclk_en, exp_st != ST_DIS);
        check(link_active == (pass_exp && lctrl), "R9 link_active", link_active, pass_exp && lctrl);
        if (pass_exp) begin
            check(ctl_out == ctl_in && data_out == data_in && req_out == req_in,
                  "R11 pass-through", {ctl_out, data_out, req_out}, {ctl_in, data_in, req_in});
        end else begin
            check(ctl_out == 2'b00 && data_out == 8'h00 && req_out == 1'b0,
                  "R3 gated", {ctl_out, data_out, req_out}, 0);
        end
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit left_active;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pwr_state == ST_DIS, "R7 during reset", pwr_state, ST_DIS);
        rst_n = 1'b1;
        step(4);
        check(pwr_state == ST_DIS && !sysclk_en, "R7 after reset, status low", pwr_state, ST_DIS);
        check_outputs(ST_DIS, 1'b1);

        for (int i = 0; i < NV; i++) begin
            status_in = VECS[i].lvl;
            link_ctrl = VECS[i].lctrl;
            ctl_in    = 2'(i + 1);
            data_in   = 8'(8'h3C ^ 8'(i * 17));
            req_in    = i[0];
            step(int'(VECS[i].hold));
            check_outputs(VECS[i].exp_st, VECS[i].lctrl);
        end

        // R10: pulsed status, low 120 / high 4, stays active
        left_active = 1'b0;
        for (int p = 0; p < 30; p++) begin
            status_in = 1'b0;
            for (int c = 0; c < 120; c++) begin
                step(1);
                if (pwr_state != ST_ACT) left_active = 1'b1;
            end
            status_in = 1'b1;
            for (int c = 0; c < 4; c++) begin
                step(1);
                if (pwr_state != ST_ACT) left_active = 1'b1;
            end
        end
        check(!left_active, "R10 pulsed status stays active", left_active, 0);

        // R8: power-down while active
        pwr_down = 1'b1;
        step(1);
        check(pwr_state == ST_DIS && !sysclk_en, "R8 power-down forces disabled", pwr_state, ST_DIS);
        check_outputs(ST_DIS, link_ctrl);
        step(5);
        check(pwr_state == ST_DIS, "R8 held while powered down", pwr_state, ST_DIS);
        pwr_down = 1'b0;
        step(2);
        check(pwr_state == ST_DIS, "R8 synchroniser cleared", pwr_state, ST_DIS);
        step(1);
        check(pwr_state == ST_ACT, "R8 return on third edge", pwr_state, ST_ACT);

        // R3: request ignored in reset state while req_in toggles
        status_in = 1'b0;
        step(131);
        check(pwr_state == ST_RST, "R2 reset after long low", pwr_state, ST_RST);
        for (int c = 0; c < 6; c++) begin
            req_in = ~req_in;
            data_in = 8'hFF;
            step(1);
            check(req_out == 1'b0 && data_out == 8'h00, "R3 request ignored", {req_out, data_out}, 0);
        end

        // R7: hardware reset from active
        status_in = 1'b1;
        step(4);
        check(pwr_state == ST_ACT, "R1 active again", pwr_state, ST_ACT);
        rst_n = 1'b0;
        #1;
        check(pwr_state == ST_DIS, "R7 reset forces disabled", pwr_state, ST_DIS);
        step(1);
        rst_n = 1'b1;
        step(3);
        check(pwr_state == ST_ACT, "R1 wake after reset release", pwr_state, ST_ACT);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule